// File: doc/BRIEF.md
# Backplane Slave Access Bridge

This block answers a backplane bus master that addresses this card and carries the access across to the host. When the master selects an address in this card's window, the block captures the address and the 128-bit write word. From then on it holds the backplane bus and works through the host handshake. A write reaches the host as four 32-bit writes. A read reaches the host as one request that returns a 128-bit word, which the block then places on the bus. The master gets a single one-cycle acknowledge, and only once the host side has finished.

The host target address comes from a mapper base value plus the captured in-window offset, scaled to 16 bytes per access. If a FIFO DMA readout may be running, a pause mode can be enabled. In that mode the block asks the DMA engine to halt for the whole slave access. When the access ends it signals a resume, but only if the readout was active when the halt was raised.

Top module: `bp_slave_bridge`

## Requirements
- R1: An access is accepted only when `bp_sel` is high while idle and `bp_addr[23:20]` equals the card identifier (default 4'hA). A non-matching address causes no hold, no host request and no acknowledge.
- R2: Address, direction and write word are captured in the accepting cycle. Later changes on `bp_addr` or `bp_wdata` do not alter the host transfer.
- R3: `bp_hold` is high from the cycle after acceptance through the acknowledge cycle, and low when idle. No acknowledge is given before the last host completion.
- R4: The host address of beat k is `map_base + 16*offset + 4*k`, where offset is `bp_addr[19:0]`. A read uses beat 0's address.
- R5: A write issues exactly four host beats with `h_wr` high. Beat k carries `bp_wdata[32k+31:32k]`, going from the least to the most significant word. Each beat holds its address and data until `h_done`.
- R6: A read issues one host request with `h_wr` low. `h_rdata` is captured on `h_done`. The captured word appears on `bp_rdata` in the acknowledge cycle, and `bp_rdata` is zero in every other cycle.
- R7: `bp_ack` is a one-cycle pulse, given exactly once per accepted access.
- R8: With `pause_en` high at acceptance, `dma_halt` is high from the cycle after acceptance through the acknowledge cycle. With `pause_en` low it stays low.
- R9: `dma_resume` pulses for one cycle, in the cycle after the acknowledge, only if `pause_en` and `dma_active` were both high in the accepting cycle.
- R10: During and after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_sel | input | 1 | Backplane master selects an address |
| bp_wr | input | 1 | 1 = write, 0 = read |
| bp_addr | input | 24 | Backplane address: identifier in the top bits, offset below |
| bp_wdata | input | 128 | Backplane write word |
| bp_hold | output | 1 | Backplane bus held by this card |
| bp_ack | output | 1 | One-cycle reply to the master |
| bp_rdata | output | 128 | Read word, valid with `bp_ack` |
| map_base | input | 32 | Mapper base address on the host side |
| h_req | output | 1 | Host beat request |
| h_wr | output | 1 | Host beat is a write |
| h_addr | output | 32 | Host target address |
| h_wdata | output | 32 | Host write data for the current beat |
| h_done | input | 1 | Host completes the current beat |
| h_rdata | input | 128 | Host read word, valid with `h_done` |
| pause_en | input | 1 | Mode: halt DMA readout during slave accesses |
| dma_active | input | 1 | FIFO DMA readout in progress |
| dma_halt | output | 1 | Halt request to the DMA engine |
| dma_resume | output | 1 | One-cycle resume pulse to the DMA engine |

## Verification
Acceptance of a slave access and a change in the DMA readout's activity can fall on the same clock edge. The resume decision must follow the value seen at that edge and ignore later changes. The bench provokes this in both directions. In one case `dma_active` is high at acceptance and drops in the next cycle, which must still give a resume pulse. In the other it is low at acceptance and rises afterwards, which must give none. Each case is judged by sampling `dma_resume` in the cycle after the acknowledge.

// File: rtl/bp_slave_bridge.sv
module bp_slave_bridge #(
  parameter int AW = 24,
  parameter int DEC_W = 4,
  parameter logic [DEC_W-1:0] CARD_ID = 'hA,
  parameter int HAW = 32,
  parameter int DW = 32,
  parameter int BEATS = 4,
  localparam int WW = DW * BEATS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bp_sel,
  input  logic           bp_wr,
  input  logic [AW-1:0]  bp_addr,
  input  logic [WW-1:0]  bp_wdata,
  output logic           bp_hold,
  output logic           bp_ack,
  output logic [WW-1:0]  bp_rdata,
  input  logic [HAW-1:0] map_base,
  output logic           h_req,
  output logic           h_wr,
  output logic [HAW-1:0] h_addr,
  output logic [DW-1:0]  h_wdata,
  input  logic           h_done,
  input  logic [WW-1:0]  h_rdata,
  input  logic           pause_en,
  input  logic           dma_active,
  output logic           dma_halt,
  output logic           dma_resume
);
  localparam int OW = AW - DEC_W;
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int ACC_SH = $clog2(WW / 8);
  localparam int BEAT_SH = $clog2(DW / 8);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WR, S_RD, S_ACK} st_t;

  st_t            st;
  logic           wr_q, was_q, halt_q, resume_q;
  logic [OW-1:0]  off_q;
  logic [WW-1:0]  wd_q, rd_q;
  logic [HAW-1:0] base_q;
  logic [BW-1:0]  beat;

  wire hit = bp_sel && (bp_addr[AW-1 -: DEC_W] == CARD_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      was_q    <= 1'b0;
      halt_q   <= 1'b0;
      resume_q <= 1'b0;
      off_q    <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
      base_q   <= '0;
      beat     <= '0;
    end else begin
      resume_q <= 1'b0;
      case (st)
        S_IDLE: if (hit) begin
          wr_q   <= bp_wr;
          off_q  <= bp_addr[OW-1:0];
          wd_q   <= bp_wdata;
          was_q  <= pause_en && dma_active;
          halt_q <= pause_en;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          base_q <= map_base + (HAW'(off_q) << ACC_SH);
          beat   <= '0;
          st     <= wr_q ? S_WR : S_RD;
        end
        S_WR: if (h_done) begin
          if (beat == BW'(BEATS - 1)) st <= S_ACK;
          else beat <= beat + 1'b1;
        end
        S_RD: if (h_done) begin
          rd_q <= h_rdata;
          st   <= S_ACK;
        end
        S_ACK: begin
          st       <= S_IDLE;
          halt_q   <= 1'b0;
          resume_q <= was_q;
          was_q    <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bp_hold    = (st != S_IDLE);
  assign bp_ack     = (st == S_ACK);
  assign bp_rdata   = (st == S_ACK && !wr_q) ? rd_q : '0;
  assign h_req      = (st == S_WR) || (st == S_RD);
  assign h_wr       = (st == S_WR);
  assign h_addr     = (st == S_WR) ? base_q + (HAW'(beat) << BEAT_SH) : base_q;
  assign h_wdata    = wd_q[beat*DW +: DW];
  assign dma_halt   = halt_q;
  assign dma_resume = resume_q;
endmodule

// File: rtl/bp_slave_bridge_chk.sv
module bp_slave_bridge_chk #(
  parameter int HAW = 32,
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bp_hold,
  input logic           bp_ack,
  input logic           h_req,
  input logic           h_done,
  input logic [HAW-1:0] h_addr,
  input logic [DW-1:0]  h_wdata,
  input logic           dma_halt,
  input logic           dma_resume
);
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bp_ack |=> !bp_ack);
  p_req_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_req |-> bp_hold);
  p_ack_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bp_ack |-> bp_hold);
  p_ack_not_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bp_ack |-> !h_req);
  p_beat_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_done) |=> (h_req && $stable(h_addr) && $stable(h_wdata)));
  p_halt_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_halt |-> bp_hold);
  p_resume_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_resume |-> ($past(bp_ack) && !bp_hold));
endmodule

bind bp_slave_bridge bp_slave_bridge_chk #(.HAW(HAW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bp_hold(bp_hold), .bp_ack(bp_ack),
  .h_req(h_req), .h_done(h_done), .h_addr(h_addr), .h_wdata(h_wdata),
  .dma_halt(dma_halt), .dma_resume(dma_resume)
);

// File: tb/bp_slave_bridge_bench.sv
module bp_slave_bridge_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bp_sel, bp_wr, h_done, pause_en, dma_active;
  logic [23:0] bp_addr;
  logic [127:0] bp_wdata, bp_rdata, h_rdata;
  logic [31:0] map_base, h_addr, h_wdata;
  logic bp_hold, bp_ack, h_req, h_wr, dma_halt, dma_resume;

  bp_slave_bridge u_bp_slave_bridge (
    .clk(clk), .rst_n(rst_n), .bp_sel(bp_sel), .bp_wr(bp_wr), .bp_addr(bp_addr),
    .bp_wdata(bp_wdata), .bp_hold(bp_hold), .bp_ack(bp_ack), .bp_rdata(bp_rdata),
    .map_base(map_base), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_done(h_done), .h_rdata(h_rdata), .pause_en(pause_en),
    .dma_active(dma_active), .dma_halt(dma_halt), .dma_resume(dma_resume)
  );

  typedef struct packed {
    logic wr; logic [19:0] off; logic [127:0] wd; logic [127:0] rd;
    logic pause; logic dact; logic dact_after; logic [3:0] lat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 20'h00001, 128'h44444444_33333333_22222222_11111111, 128'h0, 1'b1, 1'b1, 1'b1, 4'd1},
    '{1'b1, 20'h00ABC, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 128'h0, 1'b0, 1'b1, 1'b1, 4'd3},
    '{1'b0, 20'h00010, 128'h0, 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0, 1'b1, 1'b0, 1'b1, 4'd2},
    '{1'b0, 20'hFFFFF, 128'h0, 128'h12345678_9ABCDEF0_0FEDCBA9_87654321, 1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b1, 20'h00000, 128'hFFFFFFFF_00000000_AAAAAAAA_55555555, 128'h0, 1'b1, 1'b0, 1'b1, 4'd2},
    '{1'b0, 20'h00333, 128'h0, 128'h0, 1'b0, 1'b0, 1'b0, 4'd1}
  };

  int tests = 0, fails = 0;
  bit finished = 0;
  int lat = 1, nbeats = 0;
  logic [127:0] cur_rd = '0;
  logic [31:0] lg_addr [8];
  logic [31:0] lg_data [8];
  logic lg_wr [8];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int cnt = 0;
    h_done = 0; h_rdata = '0;
    forever begin
      @(negedge clk);
      h_done = 0; h_rdata = ~cur_rd;
      if (h_req) begin
        cnt++;
        if (cnt >= lat) begin
          h_done = 1; h_rdata = cur_rd; cnt = 0;
          if (nbeats < 8) begin
            lg_addr[nbeats] = h_addr; lg_data[nbeats] = h_wdata; lg_wr[nbeats] = h_wr;
          end
          nbeats++;
        end
      end else cnt = 0;
    end
  end

  task automatic do_access(input vec_t v);
    logic [31:0] base;
    int bad_hold = 0, bad_halt = 0, cyc = 0, nb_ack = 0;
    bit got = 0;
    logic [127:0] rdat = '0;
    base = map_base + {v.off, 4'b0};
    nbeats = 0; lat = int'(v.lat); cur_rd = v.rd;
    @(negedge clk);
    bp_sel = 1; bp_wr = v.wr; bp_addr = {4'hA, v.off}; bp_wdata = v.wd;
    pause_en = v.pause; dma_active = v.dact;
    @(negedge clk);
    bp_wdata = ~v.wd; bp_addr = {4'hA, ~v.off}; dma_active = v.dact_after;
    while (!got && cyc < 200) begin
      if (!bp_hold) bad_hold++;
      if (dma_halt !== v.pause) bad_halt++;
      if (bp_ack) begin
        got = 1; rdat = bp_rdata; nb_ack = nbeats; bp_sel = 0;
      end else @(negedge clk);
      cyc++;
    end
    bp_sel = 0;
    chk(got, "R7 ack received", 128'(got), 128'd1);
    chk(bad_hold == 0, "R3 hold until ack", 128'(bad_hold), 128'd0);
    chk(bad_halt == 0, "R8 halt level during access", 128'(bad_halt), 128'd0);
    chk(nb_ack == (v.wr ? 4 : 1), "R3 R5 R6 host beats before ack", 128'(nb_ack), 128'(v.wr ? 4 : 1));
    if (v.wr) begin
      for (int k = 0; k < 4; k++) begin
        chk(lg_addr[k] == base + 32'(4 * k), "R4 beat address", 128'(lg_addr[k]), 128'(base + 32'(4 * k)));
        chk(lg_data[k] == v.wd[32*k +: 32], "R5 R2 beat data order", 128'(lg_data[k]), 128'(v.wd[32*k +: 32]));
        chk(lg_wr[k] == 1'b1, "R5 beat is write", 128'(lg_wr[k]), 128'd1);
      end
      chk(rdat == '0, "R6 rdata zero on write ack", rdat, 128'd0);
    end else begin
      chk(lg_addr[0] == base, "R4 R2 read address", 128'(lg_addr[0]), 128'(base));
      chk(lg_wr[0] == 1'b0, "R6 read request", 128'(lg_wr[0]), 128'd0);
      chk(rdat == v.rd, "R6 read data on ack", rdat, v.rd);
    end
    @(negedge clk);
    chk(bp_ack == 0, "R7 ack one cycle", 128'(bp_ack), 128'd0);
    chk(dma_resume == (v.pause & v.dact), "R9 resume decision", 128'(dma_resume), 128'(v.pause & v.dact));
    chk(dma_halt == 0 && bp_hold == 0, "R8 R3 released", 128'({dma_halt, bp_hold}), 128'd0);
    chk(bp_rdata == '0, "R6 rdata zero when idle", bp_rdata, 128'd0);
    @(negedge clk);
    chk(dma_resume == 0, "R9 resume one cycle", 128'(dma_resume), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    rst_n = 0; bp_sel = 0; bp_wr = 0; bp_addr = '0; bp_wdata = '0;
    map_base = 32'h8000_0000; pause_en = 0; dma_active = 0;
    repeat (3) @(negedge clk);
    chk({bp_hold, bp_ack, h_req, dma_halt, dma_resume} == 5'b0 && bp_rdata == '0,
        "R10 reset outputs", 128'({bp_hold, bp_ack, h_req, dma_halt, dma_resume}), 128'd0);
    rst_n = 1;
    @(negedge clk);
    chk({bp_hold, bp_ack, h_req} == 3'b0, "R10 idle after reset", 128'({bp_hold, bp_ack, h_req}), 128'd0);

    foreach (VECS[i]) do_access(VECS[i]);

    nbeats = 0; seen = 0;
    @(negedge clk);
    bp_sel = 1; bp_wr = 1; bp_addr = 24'h5_00010; pause_en = 1; dma_active = 1;
    repeat (6) begin
      @(negedge clk);
      if (bp_hold || bp_ack || dma_halt) seen++;
    end
    bp_sel = 0;
    chk(seen == 0, "R1 foreign address ignored", 128'(seen), 128'd0);
    chk(nbeats == 0, "R1 no host request on miss", 128'(nbeats), 128'd0);

    map_base = 32'h0010_0000;
    do_access('{1'b0, 20'h00002, 128'h0, 128'h77, 1'b1, 1'b1, 1'b1, 4'd1});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule